// File: doc/BRIEF.md
# Addressable-Depth Serial Delay Line

This block delays a data path by a number of clock cycles that is picked at run time. Each bit of the data path runs through a chain of storage stages, and a depth address chooses which stage drives the output. The delay can therefore change from one cycle to the next, so a path can move between two latencies without a separate multiplexer. Stages are grouped in sections of 16. Sections are chained, each one fed from the last stage of the one before it, so the total depth is 16 times the section count.

The data path is WIDTH bits wide. Every bit has its own chain, and all bits share the clock enable and the depth address. This makes the block useful for lining up pipelines of unequal latency. Two outputs are provided. One is the combinational tap. The other is that tap captured in a register, which adds one more cycle of delay. The active-low reset clears only that register. The stored stage contents are never cleared.

Top module: `tapped_delay_top`

## Requirements
- R1: With the clock enable high on every edge, `tap_out` equals the `din` value sampled `depth_sel`+1 rising edges earlier. Address 0 gives a delay of 1 cycle and address 15 gives 16 cycles.
- R2: While `ce` is low, no stage shifts. `tap_out` keeps presenting the stored values, and every address still reads the data it held before `ce` fell.
- R3: `tap_out` is a combinational read of the stage array. A change of `depth_sel` changes `tap_out` in the same cycle, with no clock edge in between.
- R4: The sections are cascaded. Address bits [3:0] pick a stage within a section, and the upper bits pick the section. With the default of 2 sections, addresses 16 to 31 give delays of 17 to 32 cycles.
- R5: On a rising edge with `ce` high and `rst_n` high, `reg_out` takes the value `tap_out` had just before that edge. With `ce` low, `reg_out` holds its value.
- R6: `rst_n` low on a rising edge clears `reg_out` to all zeros. It leaves the stage contents unchanged, so `tap_out` still shows the stored data afterwards.
- R7: Each of the WIDTH bits is delayed independently, through the same depth and under the same enable as the other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output register only |
| ce | input | 1 | Shift enable for all stages and for the output register |
| din | input | WIDTH | Data entering the first stage |
| depth_sel | input | ADDR_W | Tap address; the delay is the address plus one cycle |
| tap_out | output | WIDTH | Combinational tap output |
| reg_out | output | WIDTH | Tap output registered for one more cycle |

## Verification
The hardest case to reach from the ports is a tap read across the boundary between two sections while the line is frozen. To get there, the line must first hold more than 16 known values, and then the enable must stay low while the address moves. The stimulus fills the whole 32-stage depth with a pattern whose bits differ from each other. It then drops the enable and sweeps every address, both in order and out of order, checking each read against a history kept in the bench. A mid-run reset with the enable low follows, to show that the stored data survives the clearing of the output register.

// File: rtl/tapped_delay_pkg.sv
// Shared constants and helpers for the addressable delay line.
// Assumes sections of a fixed 16 stages, addressed by 4 low address bits.
package tapped_delay_pkg;

    localparam int unsigned SEC_DEPTH = 16;
    localparam int unsigned SEC_SEL_W = 4;

    // Address width needed to reach every stage of `sections` sections.
    function automatic int unsigned addr_width(input int unsigned sections);
        int unsigned total;
        total = sections * SEC_DEPTH;
        return (total <= SEC_DEPTH) ? SEC_SEL_W : $clog2(total);
    endfunction

endpackage

// File: rtl/tapped_delay_section.sv
// One 16-stage delay section for a WIDTH-bit data path.
// Shifts when ce is high. The tap is a combinational read selected by sel.
// last_out is the final stage and feeds the next section in the cascade.
// Assumes the stage contents need no reset.
module tapped_delay_section
    import tapped_delay_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic                 clk,
    input  logic                 ce,
    input  logic [WIDTH-1:0]     din,
    input  logic [SEC_SEL_W-1:0] sel,
    output logic [WIDTH-1:0]     tap_out,
    output logic [WIDTH-1:0]     last_out
);

    logic [WIDTH-1:0] stg [SEC_DEPTH];

    // Shift the whole section by one stage on each enabled edge.
    always_ff @(posedge clk) begin
        if (ce) begin
            stg[0] <= din;
            for (int i = 1; i < int'(SEC_DEPTH); i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    // Read the addressed stage.
    always_comb begin
        tap_out = stg[sel];
    end

    assign last_out = stg[SEC_DEPTH-1];

endmodule

// File: rtl/tapped_delay_secmux.sv
// Picks one section's tap from the upper address bits.
// Addresses that point past the last section read zero.
module tapped_delay_secmux
    import tapped_delay_pkg::*;
#(
    parameter int unsigned WIDTH    = 4,
    parameter int unsigned SECTIONS = 2,
    parameter int unsigned ADDR_W   = 5
) (
    input  logic [SECTIONS-1:0][WIDTH-1:0] sec_taps,
    input  logic [ADDR_W-1:0]              sel,
    output logic [WIDTH-1:0]               tap_out
);

    logic [ADDR_W-1:0] sec_idx;

    // Select the section tap named by the upper address bits.
    always_comb begin
        sec_idx = sel >> SEC_SEL_W;
        tap_out = '0;
        for (int s = 0; s < int'(SECTIONS); s++) begin
            if (sec_idx == ADDR_W'(s)) begin
                tap_out = sec_taps[s];
            end
        end
    end

endmodule

// File: rtl/tapped_delay_outreg.sv
// Optional output register that adds one cycle after the tap.
// Synchronous active-low reset clears it. It loads only while ce is high.
module tapped_delay_outreg #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Capture the tap on enabled edges, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ce) begin
            q <= d;
        end
    end

endmodule

// File: rtl/tapped_delay_top.sv
// Addressable-depth delay line: SECTIONS cascaded 16-stage sections per bit.
// The delay is depth_sel+1 enabled cycles at tap_out, and one more at reg_out.
// Assumes reset is needed only for the output register.
module tapped_delay_top
    import tapped_delay_pkg::*;
#(
    parameter int unsigned WIDTH    = 4,
    parameter int unsigned SECTIONS = 2,
    localparam int unsigned ADDR_W  = addr_width(SECTIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic [WIDTH-1:0]  din,
    input  logic [ADDR_W-1:0] depth_sel,
    output logic [WIDTH-1:0]  tap_out,
    output logic [WIDTH-1:0]  reg_out
);

    logic [SECTIONS:0][WIDTH-1:0]   chain;
    logic [SECTIONS-1:0][WIDTH-1:0] sec_taps;

    assign chain[0] = din;

    // Build the cascade: each section takes the last stage of the one before.
    for (genvar s = 0; s < int'(SECTIONS); s++) begin : g_sec
        tapped_delay_section #(.WIDTH(WIDTH)) u_sec (
            .clk      (clk),
            .ce       (ce),
            .din      (chain[s]),
            .sel      (depth_sel[SEC_SEL_W-1:0]),
            .tap_out  (sec_taps[s]),
            .last_out (chain[s+1])
        );
    end

    tapped_delay_secmux #(
        .WIDTH    (WIDTH),
        .SECTIONS (SECTIONS),
        .ADDR_W   (ADDR_W)
    ) u_mux (
        .sec_taps (sec_taps),
        .sel      (depth_sel),
        .tap_out  (tap_out)
    );

    tapped_delay_outreg #(.WIDTH(WIDTH)) u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .d     (tap_out),
        .q     (reg_out)
    );

endmodule

// File: rtl/tapped_delay_chk.sv
// Property checker for tapped_delay_top, attached by bind below.
// It watches only the ports of the top module.
module tapped_delay_chk #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce,
    input logic [WIDTH-1:0]  din,
    input logic [ADDR_W-1:0] depth_sel,
    input logic [WIDTH-1:0]  tap_out,
    input logic [WIDTH-1:0]  reg_out
);

    // R1: at address 0 the tap shows the data sampled on the previous enabled edge.
    p_first_tap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> (depth_sel != '0 || tap_out == $past(din)));

    // R2: with the enable low and the address unchanged, the tap does not move.
    p_frozen_tap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> (depth_sel != $past(depth_sel) || $stable(tap_out)));

    // R5: an enabled edge copies the tap into the register.
    p_reg_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> reg_out == $past(tap_out));

    // R5: the register holds while the enable is low.
    p_reg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(reg_out));

    // R6: reset clears the register.
    p_reg_clear_r6: assert property (@(posedge clk)
        !rst_n |=> reg_out == '0);

endmodule

bind tapped_delay_top tapped_delay_chk #(
    .WIDTH  (WIDTH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .din       (din),
    .depth_sel (depth_sel),
    .tap_out   (tap_out),
    .reg_out   (reg_out)
);

// File: tb/sim_tapped_delay_top.sv
`timescale 1ns/1ps
module sim_tapped_delay_top;

    localparam int W     = 4;
    localparam int SECS  = 2;
    localparam int DEPTH = SECS * 16;
    localparam int AW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 1'b0;
    logic [W-1:0]  din = '0;
    logic [AW-1:0] depth_sel = '0;
    logic [W-1:0]  tap_out;
    logic [W-1:0]  reg_out;

    always #2 clk = ~clk;

    tapped_delay_top #(.WIDTH(W), .SECTIONS(SECS)) u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .din(din),
        .depth_sel(depth_sel), .tap_out(tap_out), .reg_out(reg_out)
    );

    typedef struct {
        logic [W-1:0] tap_exp;
        bit           tap_ok;
        logic [W-1:0] reg_exp;
        bit           reg_ok;
        string        req;
    } item_t;

    item_t        sb_q[$];
    event         ev_chk;
    int           n_chk = 0;
    int           n_err = 0;
    bit           done = 0;

    // Reference model kept from the requirements.
    logic [W-1:0] hist [DEPTH];
    int           filled = 0;
    logic [W-1:0] reg_m = '0;
    bit           reg_known = 0;
    logic [W-1:0] lfsr = 4'h9;

    // Driver: set inputs at the falling edge, queue the expected values, then apply the model's edge update.
    task automatic step(input bit c, input logic [W-1:0] d, input int a, input bit rn, input string req);
        item_t it;
        @(negedge clk);
        ce = c; din = d; depth_sel = AW'(a); rst_n = rn;
        it.tap_exp = hist[a];
        it.tap_ok  = (a < filled);
        it.reg_exp = reg_m;
        it.reg_ok  = reg_known;
        it.req     = req;
        sb_q.push_back(it);
        -> ev_chk;
        @(posedge clk);
        if (!rn) begin
            reg_m = '0; reg_known = 1;
        end else if (c) begin
            reg_m = it.tap_exp; reg_known = it.tap_ok;
        end
        if (c) begin
            for (int i = DEPTH-1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = d;
            if (filled < DEPTH) filled++;
        end
    endtask

    // Address change with no clock edge: the tap must follow at once (R3).
    task automatic peek(input int a, input string req);
        item_t it;
        #0.5;
        depth_sel = AW'(a);
        it.tap_exp = hist[a]; it.tap_ok = (a < filled);
        it.reg_exp = reg_m;   it.reg_ok = reg_known;
        it.req = req;
        sb_q.push_back(it);
        -> ev_chk;
        #1.2;
    endtask

    function automatic logic [W-1:0] next_pat();
        lfsr = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
        return lfsr;
    endfunction

    // Monitor: pop each queued item and compare it with the outputs.
    initial begin
        item_t it;
        forever begin
            @(ev_chk);
            #1;
            it = sb_q.pop_front();
            if (it.tap_ok) begin
                n_chk++;
                if (tap_out !== it.tap_exp) begin
                    n_err++;
                    $display("FAIL %s tap_out addr=%0d actual=%h expected=%h", it.req, depth_sel, tap_out, it.tap_exp);
                end
            end
            if (it.reg_ok) begin
                n_chk++;
                if (reg_out !== it.reg_exp) begin
                    n_err++;
                    $display("FAIL %s reg_out actual=%h expected=%h", it.req, reg_out, it.reg_exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R6: reset state of the output register.
        step(0, 4'h0, 0, 0, "R6 reset");
        step(0, 4'h0, 0, 0, "R6 reset");
        step(0, 4'h0, 0, 1, "R6 after reset");
        // R1/R7: fill with per-bit distinct patterns, short taps.
        for (int k = 0; k < 20; k++) step(1, next_pat(), k % 4, 1, "R1 R7 short delay");
        // R1: delays of 16 at the edge of the first section.
        for (int k = 0; k < 6; k++) step(1, next_pat(), 15, 1, "R1 delay 16");
        // R4: cascaded depth, addresses in the second section.
        for (int k = 0; k < 12; k++) step(1, next_pat(), 16 + (k * 5) % 16, 1, "R4 cascade");
        step(1, next_pat(), 31, 1, "R4 max delay 32");
        step(1, next_pat(), 16, 1, "R4 delay 17");
        // R2: enable low, sweep every address across both sections.
        for (int a = 0; a < DEPTH; a++) step(0, ~lfsr, a, 1, "R2 frozen sweep");
        for (int a = DEPTH-1; a >= 0; a -= 3) step(0, lfsr, a, 1, "R2 frozen reverse");
        // R3: address moves between edges.
        @(negedge clk);
        peek(3, "R3 same-cycle"); peek(17, "R3 same-cycle"); peek(30, "R3 same-cycle");
        // R5: enable toggling; register follows only on enabled edges.
        for (int k = 0; k < 16; k++) step(k % 3 != 0, next_pat(), (k * 7) % DEPTH, 1, "R5 register");
        // R6: reset with enable low keeps stage data.
        step(0, 4'h0, 5, 0, "R6 mid reset");
        step(0, 4'h0, 5, 1, "R6 cleared");
        for (int a = 0; a < DEPTH; a += 4) step(0, 4'h0, a, 1, "R6 data kept");
        // R7: all-ones / all-zeros bit mixes.
        step(1, 4'hF, 0, 1, "R7 mix");
        step(1, 4'h0, 0, 1, "R7 mix");
        step(1, 4'hA, 1, 1, "R7 mix");
        step(1, 4'h5, 1, 1, "R7 mix");
        step(0, 4'h0, 2, 1, "R7 mix");
        @(negedge clk);
        #2;
        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule